// File: doc/BRIEF.md
# Gate-Drive Chopping Modulator

This block sits between a three-phase PWM generator and the gate drivers. It receives six raw switch levels, three for the high-side switches and three for the low-side switches. It can superimpose a high-frequency square carrier on any switch that is currently on, so that the drive signal can be coupled through a pulse transformer. Switches that are off stay off.

A single configuration word sets the carrier. It holds an 8-bit divisor and one chopping enable for each switch group. The carrier period is four times (divisor + 1) core clock cycles, which spans 4 to 1024 cycles. The word is meant to be loaded before the PWM starts and left alone while the PWM runs. Every load restarts the carrier from the beginning of its high half, so a load never produces a shortened carrier pulse.

Top module: `gate_chop_mod`

## Requirements
- R1: After reset the configuration is all zero. Both groups then pass their raw inputs to the outputs unchanged.
- R2: The carrier is a square wave with a period of 4×(D+1) clock cycles, where D is the loaded divisor. It is high for the first 2×(D+1) cycles and low for the next 2×(D+1) cycles.
- R3: While the high-side enable is set, each high-side output equals its raw input AND the carrier.
- R4: The low-side enable acts only on the low-side group. A group whose enable is clear passes its raw inputs through unchanged, whatever the other group's setting.
- R5: An output is never high while its raw input is low. Chopping only affects switches that are on.
- R6: Every configuration load restarts the carrier. The carrier is high from the cycle after the load edge for a full 2×(D+1) cycles, even if the load lands in the middle of a carrier half.
- R7: The configuration word is taken on a rising clock edge while `cfg_wr` is high. Its fields are: bits 7:0 the divisor, bit 8 the high-side enable, bit 9 the low-side enable.
- R8: The divisor range ends give the shortest and longest carrier periods. D = 0 gives a period of 4 cycles and D = 255 gives a period of 1024 cycles.
- R9: Raw input changes reach the outputs in the same cycle, with no register in that path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| cfg_wr | input | 1 | Configuration load strobe |
| cfg_wdata | input | 10 | Configuration word: {low enable, high enable, divisor} |
| pwm_hi_in | input | 3 | Raw high-side switch levels |
| pwm_lo_in | input | 3 | Raw low-side switch levels |
| pwm_hi_out | output | 3 | Chopped high-side levels |
| pwm_lo_out | output | 3 | Chopped low-side levels |

## Verification
The raw-to-output path has no register, so the bench changes raw levels on a falling edge and checks the outputs shortly afterwards in the same cycle. A configuration load takes effect at the rising edge that samples `cfg_wr`. The falling edge that follows is counted as carrier cycle zero, and from there the bench predicts the carrier at every falling edge as high exactly when the cycle index modulo 4×(D+1) is below 2×(D+1). This prediction is checked against the outputs for two whole periods at each divisor tested. A reload in the middle of a low half resets the index to zero.

// File: rtl/chop_pkg.sv
package chop_pkg;
  localparam int unsigned CHOP_DIV_W  = 8;
  localparam int unsigned CHOP_PHASES = 3;
  // configuration word layout relative to divisor width
  function automatic int unsigned hi_en_bit(input int unsigned div_w);
    return div_w;
  endfunction
  function automatic int unsigned lo_en_bit(input int unsigned div_w);
    return div_w + 1;
  endfunction
endpackage

// File: rtl/chop_cfg_reg.sv
module chop_cfg_reg #(
  parameter int unsigned DIV_W = chop_pkg::CHOP_DIV_W,
  localparam int unsigned CFG_W = DIV_W + 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [CFG_W-1:0] wdata,
  output logic [DIV_W-1:0] div,
  output logic             hi_en,
  output logic             lo_en,
  output logic             restart
);
  localparam int unsigned HI_B = chop_pkg::hi_en_bit(DIV_W);
  localparam int unsigned LO_B = chop_pkg::lo_en_bit(DIV_W);

  logic [CFG_W-1:0] cfg_q, cfg_d;

  always_comb begin
    cfg_d = cfg_q;
    if (wr) cfg_d = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_q <= '0;
    else        cfg_q <= cfg_d;
  end

  assign div     = cfg_q[DIV_W-1:0];
  assign hi_en   = cfg_q[HI_B];
  assign lo_en   = cfg_q[LO_B];
  assign restart = wr;

  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr |=> $stable(cfg_q)); // R7
  AST_CFG_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    wr |=> (cfg_q == $past(wdata))); // R7
endmodule

// File: rtl/chop_prescaler.sv
module chop_prescaler #(
  parameter int unsigned DIV_W = chop_pkg::CHOP_DIV_W,
  localparam int unsigned HALF_W = DIV_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div,
  input  logic             restart,
  output logic             carrier
);
  logic [HALF_W-1:0] hcnt_q, hcnt_d;
  logic              car_q, car_d;
  logic [HALF_W-1:0] half_last;
  logic              tick_en;
  logic              wrap;

  // last count of a half period: 2*(div+1)-1
  assign half_last = {div, 1'b1};
  assign tick_en   = 1'b1;
  assign wrap      = (hcnt_q == half_last);

  always_comb begin
    hcnt_d = hcnt_q;
    car_d  = car_q;
    if (restart) begin
      hcnt_d = '0;
      car_d  = 1'b1;
    end else if (tick_en) begin
      if (wrap) begin
        hcnt_d = '0;
        car_d  = ~car_q;
      end else begin
        hcnt_d = hcnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hcnt_q <= '0;
      car_q  <= 1'b1;
    end else begin
      hcnt_q <= hcnt_d;
      car_q  <= car_d;
    end
  end

  assign carrier = car_q;

  AST_HALF_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(div) |=> (hcnt_q <= half_last)); // R2
  AST_RESTART_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (car_q && hcnt_q == '0)); // R6
  AST_FLIP_AT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (!restart && wrap) |=> (car_q != $past(car_q))); // R2
  AST_HOLD_MID_HALF: assert property (@(posedge clk) disable iff (!rst_n)
    (!restart && !wrap) |=> $stable(car_q)); // R2
endmodule

// File: rtl/chop_gate.sv
module chop_gate #(
  parameter int unsigned N = chop_pkg::CHOP_PHASES
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] raw,
  input  logic         carrier,
  input  logic         en,
  output logic [N-1:0] chopped
);
  logic pass;
  assign pass = carrier | ~en;

  for (genvar i = 0; i < N; i++) begin : g_leg
    assign chopped[i] = raw[i] & pass;
  end

  AST_OFF_STAYS_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (chopped & ~raw) == '0); // R5
  AST_BYPASS: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> (chopped == raw)); // R4
  AST_CHOP_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !carrier) |-> (chopped == '0)); // R3
endmodule

// File: rtl/gate_chop_mod.sv
module gate_chop_mod #(
  parameter int unsigned DIV_W  = chop_pkg::CHOP_DIV_W,
  parameter int unsigned PHASES = chop_pkg::CHOP_PHASES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic [DIV_W+1:0]  cfg_wdata,
  input  logic [PHASES-1:0] pwm_hi_in,
  input  logic [PHASES-1:0] pwm_lo_in,
  output logic [PHASES-1:0] pwm_hi_out,
  output logic [PHASES-1:0] pwm_lo_out
);
  logic [DIV_W-1:0] div;
  logic             hi_en, lo_en, restart, carrier;

  chop_cfg_reg #(.DIV_W(DIV_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr(cfg_wr), .wdata(cfg_wdata),
    .div(div), .hi_en(hi_en), .lo_en(lo_en), .restart(restart)
  );

  chop_prescaler #(.DIV_W(DIV_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .div(div), .restart(restart), .carrier(carrier)
  );

  chop_gate #(.N(PHASES)) u_hi (
    .clk(clk), .rst_n(rst_n), .raw(pwm_hi_in), .carrier(carrier),
    .en(hi_en), .chopped(pwm_hi_out)
  );

  chop_gate #(.N(PHASES)) u_lo (
    .clk(clk), .rst_n(rst_n), .raw(pwm_lo_in), .carrier(carrier),
    .en(lo_en), .chopped(pwm_lo_out)
  );
endmodule

// File: tb/gate_chop_mod_test.sv
module gate_chop_mod_test;
  localparam time CLK_PERIOD = 10ns;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_wr = 1'b0;
  logic [9:0] cfg_wdata = '0;
  logic [2:0] pwm_hi_in = '0, pwm_lo_in = '0;
  logic [2:0] pwm_hi_out, pwm_lo_out;

  int checks = 0;
  int failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gate_chop_mod uut (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
    .pwm_hi_in(pwm_hi_in), .pwm_lo_in(pwm_lo_in),
    .pwm_hi_out(pwm_hi_out), .pwm_lo_out(pwm_lo_out)
  );

  task automatic chk(input string req, input logic [2:0] act, input logic [2:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic car_exp(input int d, input int k);
    return (k % (4*(d+1))) < (2*(d+1));
  endfunction

  // load config; returns at the falling edge that is carrier cycle 0 (R7)
  task automatic load_cfg(input int d, input bit hi, input bit lo);
    @(negedge clk);
    cfg_wr = 1'b1;
    cfg_wdata = {lo, hi, d[7:0]};
    @(posedge clk);
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic t_reset;
    pwm_hi_in = 3'b101; pwm_lo_in = 3'b011;
    #1;
    chk("R1 hi passthrough after reset", pwm_hi_out, 3'b101);
    chk("R1 lo passthrough after reset", pwm_lo_out, 3'b011);
    repeat (5) @(negedge clk);
    chk("R1 hi still passthrough", pwm_hi_out, 3'b101);
    chk("R1 lo still passthrough", pwm_lo_out, 3'b011);
  endtask

  // both-group carrier over two periods with raw all ones (R2, R3, R4, R8)
  task automatic t_carrier(input int d, input bit hi, input bit lo, input string req);
    pwm_hi_in = 3'b111; pwm_lo_in = 3'b111;
    load_cfg(d, hi, lo);
    for (int k = 0; k < 8*(d+1); k++) begin
      #1;
      chk({req, " hi"}, pwm_hi_out, hi ? {3{car_exp(d, k)}} : 3'b111);
      chk({req, " lo"}, pwm_lo_out, lo ? {3{car_exp(d, k)}} : 3'b111);
      @(negedge clk);
    end
  endtask

  // raw patterns while chopping: same-cycle response, off stays off (R5, R9, R3)
  task automatic t_patterns;
    load_cfg(2, 1'b1, 1'b1);
    for (int k = 0; k < 24; k++) begin
      logic c;
      c = car_exp(2, k);
      pwm_hi_in = 3'(k * 5 + 1);
      pwm_lo_in = 3'(k * 3 + 2);
      #1;
      chk("R9 R3 hi pattern same cycle", pwm_hi_out, pwm_hi_in & {3{c}});
      chk("R5 lo pattern off stays off", pwm_lo_out & ~pwm_lo_in, 3'b000);
      chk("R9 lo pattern same cycle", pwm_lo_out, pwm_lo_in & {3{c}});
      @(negedge clk);
    end
  endtask

  // reload in the middle of a low half restarts carrier (R6)
  task automatic t_restart;
    pwm_hi_in = 3'b111; pwm_lo_in = 3'b000;
    load_cfg(1, 1'b1, 1'b0);
    repeat (5) @(negedge clk);
    #1;
    chk("R6 in low half before reload", pwm_hi_out, 3'b000);
    load_cfg(1, 1'b1, 1'b0);
    for (int k = 0; k < 16; k++) begin
      #1;
      chk("R6 restart from high half", pwm_hi_out, {3{car_exp(1, k)}});
      chk("R5 lo raw low stays low", pwm_lo_out, 3'b000);
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_carrier(0, 1'b1, 1'b1, "R8 R2 div0");
    t_carrier(3, 1'b1, 1'b0, "R4 R3 hi only");
    t_carrier(4, 1'b0, 1'b1, "R4 lo only");
    t_carrier(255, 1'b1, 1'b1, "R8 R2 div255");
    t_carrier(7, 1'b0, 1'b0, "R4 both off");
    t_patterns();
    t_restart();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule